// File: doc/BRIEF.md
# Revolution Carry Flag Generator

This block marks each completed revolution (or pitch) of a tracked angular position counter. Every clock it compares the present counter value with the value from the previous cycle, both reduced to the selected resolution. A wrap from all ones to all zeros is a carry. A wrap from all zeros to all ones is a borrow. Either one raises the output flag `rcOut` on the next clock edge.

The flag does not fall on a fixed timeout. Its release follows the step strobe `busyIn` and the direction input `dirIn`. In the normal case, one BUSY pulse arrives after the wrap with the direction unchanged, and the flag is released when that pulse ends. If the direction differs at a BUSY rising edge while the flag is high, release waits until the direction has held steady over two further BUSY rising edges. In every case the flag stays high for at least a parameterised number of clock cycles.

A downstream revolution counter may gate `rcOut` with `busyIn`. That counter lives outside this block.

Top module: `revCarryFlag`

## Requirements
- R1: When the masked counter goes from all ones to all zeros between two consecutive cycles, `rcOut` is 1 after the next clock edge. A step that is not such a wrap leaves `rcOut` low.
- R2: When the masked counter goes from all zeros to all ones between two consecutive cycles, `rcOut` is 1 after the next clock edge.
- R3: `resSel` picks the compared width: 0 gives the low 10 bits, 1 gives 12, 2 gives 14 and 3 gives all 16 bits. Bits above the chosen width never cause or block a wrap.
- R4: The flag is armed at a BUSY falling edge when every BUSY rising edge since the wrap showed `dirIn` equal to its value at the wrap, and at least one such edge occurred. The flag clears one cycle after it is armed, provided the minimum width has also been met.
- R5: Once raised, `rcOut` stays high for at least MIN_HIGH clock cycles (MIN_HIGH=30 by default, 300 ns at 100 MHz).
- R6: If `dirIn` at a BUSY rising edge differs from its value at the previous BUSY rising edge (or at the wrap), arming is possible only after two later consecutive BUSY rising edges with `dirIn` unchanged.
- R7: A direction change seen at a BUSY rising edge while the flag is armed but not yet cleared cancels the arming, and R6 then applies.
- R8: A new wrap while `rcOut` is high keeps it high, restarts the minimum-width count and discards any progress toward arming.
- R9: During reset `rcOut` is 0. The first cycle after reset is not compared for a wrap, so `rcOut` is still 0 after the first edge whatever `posValue` holds.
- R10: Without BUSY activity, a raised `rcOut` stays high indefinitely, even after the minimum width has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| posValue | input | POS_W (16) | Tracked position counter value |
| resSel | input | SEL_W (2) | Resolution select: 0=10, 1=12, 2=14, 3=16 bits |
| busyIn | input | 1 | Step strobe, one pulse per counter step |
| dirIn | input | 1 | Step direction: 1 counts up, 0 counts down |
| rcOut | output | 1 | Revolution carry flag |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `posValue` moves by at most one wrap per cycle, and that a BUSY edge never lands in the same cycle as a wrap. Under those assumptions, each rise of the flag traces back to a wrap, and each fall traces back to an expired width timer. The stimulus changes inputs only on the falling clock edge. It moves the counter through neutral mid-range values before every intended wrap, and it switches `resSel` only while the counter sits at a value that is neither all ones nor all zeros at any width. It also keeps each BUSY level for whole cycles, apart from the wrap cycle.

// File: rtl/rcPkg.sv
package rcPkg;

  // Events reported by the datapath to the control.
  typedef struct packed {
    logic wrap;          // carry or borrow seen this cycle
    logic busyRise;      // step strobe rising
    logic busyFall;      // step strobe falling
    logic dirDiff;       // direction differs from the tracked reference
    logic stableEnough;  // enough steady rising edges to arm
    logic timerDone;     // minimum width reached
  } rcEventT;

  // Strobes issued by the control to the datapath.
  typedef struct packed {
    logic restart;  // reload width timer and direction tracker
    logic track;    // flag is high: run timer and follow BUSY edges
  } rcStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_ARMED = 2'd2
  } rcStateT;

endpackage

// File: rtl/rcWrapDetect.sv
module rcWrapDetect #(
  parameter int POS_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] posValue,
  input  logic [SEL_W-1:0] resSel,
  output logic             wrapUp,
  output logic             wrapDown
);

  localparam int N_RES  = 1 << SEL_W;
  localparam int STEP_W = 2;

  logic [POS_W-1:0] maskTab [N_RES];

  // Resolution widths climb by STEP_W bits per select code, top code = POS_W.
  for (genvar s = 0; s < N_RES; s++) begin : g_mask
    localparam int RES_W = POS_W - STEP_W * (N_RES - 1 - s);
    assign maskTab[s] = {POS_W{1'b1}} >> (POS_W - RES_W);
  end

  logic [POS_W-1:0] prevPos;
  logic             primed;
  logic [POS_W-1:0] mask;
  logic [POS_W-1:0] curM;
  logic [POS_W-1:0] prevM;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPos <= '0;
      primed  <= 1'b0;
    end else begin
      prevPos <= posValue;
      primed  <= 1'b1;
    end
  end

  always_comb begin
    mask     = maskTab[resSel];
    curM     = posValue & mask;
    prevM    = prevPos & mask;
    wrapUp   = primed && (prevM == mask) && (curM == '0);
    wrapDown = primed && (prevM == '0) && (curM == mask);
  end

endmodule

// File: rtl/rcWidthTimer.sv
module rcWidthTimer #(
  parameter int MIN_HIGH = 30
) (
  input  logic clk,
  input  logic rstN,
  input  logic restart,
  input  logic run,
  output logic done
);

  localparam int CNT_W = (MIN_HIGH < 2) ? 1 : $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_HIGH - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt >= LAST);

endmodule

// File: rtl/rcDatapath.sv
module rcDatapath
  import rcPkg::*;
#(
  parameter int POS_W    = 16,
  parameter int SEL_W    = 2,
  parameter int MIN_HIGH = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] posValue,
  input  logic [SEL_W-1:0] resSel,
  input  logic             busyIn,
  input  logic             dirIn,
  input  rcStrobeT         strobe,
  output rcEventT          evt
);

  localparam logic [1:0] STABLE_TWO = 2'd2;

  logic wrapUp;
  logic wrapDown;
  logic timerDone;

  rcWrapDetect #(
    .POS_W (POS_W),
    .SEL_W (SEL_W)
  ) u_wrap (
    .clk      (clk),
    .rstN     (rstN),
    .posValue (posValue),
    .resSel   (resSel),
    .wrapUp   (wrapUp),
    .wrapDown (wrapDown)
  );

  rcWidthTimer #(
    .MIN_HIGH (MIN_HIGH)
  ) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strobe.restart),
    .run     (strobe.track),
    .done    (timerDone)
  );

  // BUSY edge detection
  logic busyQ;
  logic busyRise;
  logic busyFall;

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= busyIn;
  end

  assign busyRise = busyIn & ~busyQ;
  assign busyFall = ~busyIn & busyQ;

  // Direction tracker: reference updated at wrap and at every tracked rising edge
  logic       dirRef;
  logic [1:0] stableCnt;
  logic       needTwo;
  logic       dirDiff;

  assign dirDiff = (dirIn != dirRef);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirRef    <= 1'b0;
      stableCnt <= '0;
      needTwo   <= 1'b0;
    end else if (strobe.restart) begin
      dirRef    <= dirIn;
      stableCnt <= '0;
      needTwo   <= 1'b0;
    end else if (strobe.track && busyRise) begin
      dirRef <= dirIn;
      if (dirDiff) begin
        stableCnt <= '0;
        needTwo   <= 1'b1;
      end else if (stableCnt != STABLE_TWO) begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end

  always_comb begin
    evt.wrap         = wrapUp | wrapDown;
    evt.busyRise     = busyRise;
    evt.busyFall     = busyFall;
    evt.dirDiff      = dirDiff;
    evt.stableEnough = needTwo ? (stableCnt == STABLE_TWO) : (stableCnt != 2'd0);
    evt.timerDone    = timerDone;
  end

endmodule

// File: rtl/rcControl.sv
module rcControl
  import rcPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  rcEventT  evt,
  output rcStrobeT strobe,
  output logic     rcOut
);

  rcStateT state;
  rcStateT nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (evt.wrap) nextState = ST_HOLD;
      end
      ST_HOLD: begin
        if (evt.wrap)                              nextState = ST_HOLD;
        else if (evt.busyFall && evt.stableEnough) nextState = ST_ARMED;
      end
      ST_ARMED: begin
        if (evt.wrap)                         nextState = ST_HOLD;
        else if (evt.busyRise && evt.dirDiff) nextState = ST_HOLD;
        else if (evt.timerDone)               nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.restart = evt.wrap;
    strobe.track   = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rcOut <= 1'b0;
    end else begin
      state <= nextState;
      rcOut <= (nextState != ST_IDLE);
    end
  end

endmodule

// File: rtl/revCarryFlag.sv
module revCarryFlag
  import rcPkg::*;
#(
  parameter int POS_W    = 16,
  parameter int SEL_W    = 2,
  parameter int MIN_HIGH = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] posValue,
  input  logic [SEL_W-1:0] resSel,
  input  logic             busyIn,
  input  logic             dirIn,
  output logic             rcOut
);

  rcEventT  evt;
  rcStrobeT strobe;

  rcDatapath #(
    .POS_W    (POS_W),
    .SEL_W    (SEL_W),
    .MIN_HIGH (MIN_HIGH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .posValue (posValue),
    .resSel   (resSel),
    .busyIn   (busyIn),
    .dirIn    (dirIn),
    .strobe   (strobe),
    .evt      (evt)
  );

  rcControl u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .evt    (evt),
    .strobe (strobe),
    .rcOut  (rcOut)
  );

endmodule

// File: rtl/revCarryFlag_checker.sv
module revCarryFlag_checker #(
  parameter int MIN_HIGH = 30
) (
  input logic clk,
  input logic rstN,
  input logic rcOut,
  input logic wrapEvt,
  input logic timerDone
);

  logic [31:0] highCnt;
  logic        seenEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt  <= '0;
      seenEdge <= 1'b0;
    end else begin
      seenEdge <= 1'b1;
      if (!rcOut)                     highCnt <= '0;
      else if (highCnt != '1)         highCnt <= highCnt + 1'b1;
    end
  end

  // R1 / R2: a detected wrap raises the flag on the next edge
  assert_wrap_sets_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> rcOut);

  // R1: a rising flag always follows a wrap
  assert_rise_needs_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rcOut) |-> $past(wrapEvt));

  // R5: the flag never falls before the minimum width
  assert_min_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rcOut) |-> (highCnt >= 32'(MIN_HIGH - 1)));

  // R5: a fall is always preceded by an expired width timer
  assert_fall_after_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rcOut) |-> $past(timerDone));

  // R8: a wrap while high never lets the flag drop
  assert_no_fall_on_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rcOut) |-> !$past(wrapEvt));

  // R9: nothing is raised by the first edge after reset
  assert_first_cycle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !seenEdge |=> !rcOut);

endmodule

bind revCarryFlag revCarryFlag_checker #(.MIN_HIGH(MIN_HIGH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rcOut     (rcOut),
  .wrapEvt   (evt.wrap),
  .timerDone (evt.timerDone)
);

// File: tb/revCarryFlag_bench.sv
module revCarryFlag_bench;

  localparam int BMIN = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] posValue;
  logic [1:0]  resSel;
  logic        busyIn;
  logic        dirIn;
  logic        rcOut;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic  exp;
    string req;
  } itemT;

  itemT q[$];
  itemT it;

  always #5 clk = ~clk;

  revCarryFlag #(
    .POS_W    (16),
    .SEL_W    (2),
    .MIN_HIGH (BMIN)
  ) u_revCarryFlag (
    .clk      (clk),
    .rstN     (rstN),
    .posValue (posValue),
    .resSel   (resSel),
    .busyIn   (busyIn),
    .dirIn    (dirIn),
    .rcOut    (rcOut)
  );

  // Driver: push the expected output for the coming edge, then advance
  task automatic tick(input logic e, input string r);
    q.push_back('{exp: e, req: r});
    @(negedge clk);
  endtask

  task automatic settle(input logic [15:0] p);
    posValue = p;
    tick(1'b0, "R1 neutral value");
    tick(1'b0, "R1 neutral value");
  endtask

  // Wrap ticked at E0: BUSY pulse at E1/E2, then width expiry at E(BMIN)
  task automatic normalRun(input string r);
    busyIn = 1'b1; tick(1'b1, r);
    busyIn = 1'b0; tick(1'b1, r);
    for (int i = 0; i < BMIN - 3; i++) tick(1'b1, "R5 width held");
    tick(1'b0, r);
  endtask

  // Monitor: compare after every edge that has a pending expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (rcOut !== it.exp) begin
          errors++;
          $display("FAIL %s: rcOut=%b expected %b at %0t", it.req, rcOut, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; posValue = 16'hFFFF; resSel = 2'd3; busyIn = 1'b0; dirIn = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (rcOut !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: rcOut=%b expected 0", rcOut);
    end
    rstN = 1'b1;
    tick(1'b0, "R9 first cycle not compared");

    // R1 plain step and carry
    settle(16'h1234);
    posValue = 16'h1235; tick(1'b0, "R1 plain step");
    posValue = 16'hFFFF; tick(1'b0, "R1 plain step");
    posValue = 16'h0000; tick(1'b1, "R1 carry");
    normalRun("R4 normal clear");

    // R2 borrow
    settle(16'h8000);
    settle(16'h0000);
    posValue = 16'hFFFF; tick(1'b1, "R2 borrow");
    normalRun("R2 borrow clear");

    // R10 no BUSY activity keeps flag high
    settle(16'h8000);
    posValue = 16'hFFFF; tick(1'b0, "R1 plain step");
    posValue = 16'h0000; tick(1'b1, "R1 carry");
    for (int i = 0; i < 10; i++) tick(1'b1, "R10 no busy");
    busyIn = 1'b1; tick(1'b1, "R10 busy rise");
    busyIn = 1'b0; tick(1'b1, "R10 busy fall");
    tick(1'b0, "R10 clear after pulse");

    // R6 direction change during flag
    settle(16'h8000);
    dirIn = 1'b1;
    posValue = 16'hFFFF; tick(1'b0, "R1 plain step");
    posValue = 16'h0000; tick(1'b1, "R1 carry");
    busyIn = 1'b1; dirIn = 1'b0; tick(1'b1, "R6 change edge");
    busyIn = 1'b0; tick(1'b1, "R6 change edge");
    busyIn = 1'b1; tick(1'b1, "R6 first steady edge");
    busyIn = 1'b0; tick(1'b1, "R6 one steady edge not enough");
    busyIn = 1'b1; tick(1'b1, "R6 second steady edge");
    busyIn = 1'b0; tick(1'b1, "R6 armed");
    tick(1'b0, "R6 clear");

    // R7 change while armed
    settle(16'h8000);
    dirIn = 1'b1;
    posValue = 16'hFFFF; tick(1'b0, "R1 plain step");
    posValue = 16'h0000; tick(1'b1, "R1 carry");
    busyIn = 1'b1; tick(1'b1, "R7 steady edge");
    busyIn = 1'b0; tick(1'b1, "R7 armed");
    busyIn = 1'b1; dirIn = 1'b0; tick(1'b1, "R7 change cancels");
    busyIn = 1'b0; tick(1'b1, "R7 change cancels");
    for (int i = 0; i < 4; i++) tick(1'b1, "R7 held after cancel");
    busyIn = 1'b1; tick(1'b1, "R7 steady edge");
    busyIn = 1'b0; tick(1'b1, "R7 one steady edge not enough");
    busyIn = 1'b1; tick(1'b1, "R7 second steady edge");
    busyIn = 1'b0; tick(1'b1, "R7 rearmed");
    tick(1'b0, "R7 clear");

    // R8 retrigger
    dirIn = 1'b1;
    settle(16'h8000);
    posValue = 16'hFFFF; tick(1'b0, "R1 plain step");
    posValue = 16'h0000; tick(1'b1, "R1 carry");
    posValue = 16'hFFFF; tick(1'b1, "R8 second wrap");
    busyIn = 1'b1; tick(1'b1, "R8 busy rise");
    busyIn = 1'b0; tick(1'b1, "R8 armed");
    for (int i = 0; i < 3; i++) tick(1'b1, "R8 restarted width");
    tick(1'b0, "R8 clear");

    // R3 resolution select
    settle(16'h0155);
    resSel = 2'd0; tick(1'b0, "R3 switch width");
    posValue = 16'hA3FF; tick(1'b0, "R3 10-bit top");
    posValue = 16'hA400; tick(1'b1, "R3 10-bit carry");
    normalRun("R3 10-bit clear");

    settle(16'h0155);
    resSel = 2'd1; tick(1'b0, "R3 switch width");
    posValue = 16'h2FFF; tick(1'b0, "R3 12-bit top");
    posValue = 16'h3000; tick(1'b1, "R3 12-bit carry");
    normalRun("R3 12-bit clear");

    settle(16'h0155);
    resSel = 2'd2; tick(1'b0, "R3 switch width");
    posValue = 16'h3FFF; tick(1'b0, "R3 14-bit top");
    posValue = 16'h4000; tick(1'b1, "R3 14-bit carry");
    normalRun("R3 14-bit clear");

    settle(16'h0155);
    resSel = 2'd3; tick(1'b0, "R3 switch width");
    posValue = 16'h03FF; tick(1'b0, "R3 16-bit no wrap");
    posValue = 16'h0400; tick(1'b0, "R3 16-bit no wrap");
    posValue = 16'h0FFF; tick(1'b0, "R3 16-bit no wrap");
    posValue = 16'h1000; tick(1'b0, "R3 16-bit no wrap");

    @(posedge clk);
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule